// File: doc/BRIEF.md
# Inter-Core Mailbox Channel with Automatic Acknowledge

This block is a single mailbox channel that lets one processor core pass a short message to one or more other cores. It drives one interrupt line to each of up to 32 cores. Registers are reached through a simple register-mapped port. A write carries the binary index of the issuing core, so the channel can decide which writes to honour. A sending core first claims the mailbox by writing its one-hot channel ID into the owner register. It then fills the payload words, sets the destination bitmask and raises the message bit of the two-bit send register. Every core in the destination mask is then interrupted.

There are two ways to answer a message. In manual mode a destination drops the message bit itself and may raise the acknowledge bit, which interrupts the owner. In automatic mode each destination writes its own one-hot ID to a clear location, which strips its bit from the mask. Once the mask is empty, the channel swaps the message bit for the acknowledge bit without software help. The owner frees the channel by writing zero to the owner register.

Register map (word addresses): 0 owner, 1 destination set, 2 destination clear, 3 mode, 4 send, 8 and up payload words. Reads of address 1 or 2 return the destination mask. Mode bit 0 enables automatic acknowledge. Mode bit 1 is a stored chaining flag with no effect inside this channel. Send encodings are 00 idle, 01 message pending and 10 acknowledge. The value 11 is never held.

Top module: `ipc_mailbox`

## Requirements
- R1: While send bit 0 is set, irq[i] is high for every core i whose bit is set in the destination mask (address 1/2). Writing send to 00 drops those lines on the next cycle.
- R2: While send holds 10, irq is high only for the owner core (its bit in the owner register). Writing send back to 00 drops it.
- R3: A send write of 11 is dropped and send keeps its value. A single write may move send from 01 to 10. Send never holds 11.
- R4: While the owner register (address 0) is zero, writes to send, mode, destination set/clear and payload words change nothing.
- R5: A write to address 0 claims the channel only when the owner register is zero and the written value is one-hot. A write of zero by the owner core releases the channel: owner, send, mode and destination mask become zero and all irq lines drop. An owner write by any other core is ignored.
- R6: A send write is accepted only from the owner core or from a core whose bit is set in the destination mask.
- R7: With mode bit 0 set and send at 01, writing a one-hot ID to address 2 removes that bit from the mask. One cycle after the mask becomes empty, send changes from 01 to 10, raising the owner interrupt.
- R8: Automatic acknowledge works with a single destination, that is, a system of only two cores.
- R9: With mode bit 0 clear, emptying the mask does not raise an acknowledge: send stays 01 until a core writes it.
- R10: Payload words are 32 bits and read back as written. Mode reads back both bits, including the chaining flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write word address |
| wr_data | input | BUS_W | Write data |
| wr_core | input | CID_W | Binary index of the core issuing the write |
| rd_addr | input | ADDR_W | Read word address |
| rd_data | output | BUS_W | Read data (combinational) |
| irq | output | NUM_CORES | One interrupt line per core |

## Verification
The bench drains a three-destination mask one core at a time. It checks that send stays at 01 in the cycle the mask empties and becomes 10 exactly one cycle later. A design that acknowledged early, or never, would fail that check. A manual-mode pass drains the mask and confirms that no acknowledge appears, which catches a design that ignored the mode bit. Illegal 11 writes, send writes from outsider cores and writes to an unclaimed channel are each followed by readback. A design that stored these writes, or let an outsider drop a pending message, shows a changed register or interrupt. Release by a non-owner and by the owner checks that only the owner can clear the state and drop every line.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int A_OWNER = 0;
  localparam int A_DSET  = 1;
  localparam int A_DCLR  = 2;
  localparam int A_MODE  = 3;
  localparam int A_SEND  = 4;
  localparam int A_DATA0 = 8;

  localparam logic [1:0] SEND_IDLE = 2'b00;
  localparam logic [1:0] SEND_MSG  = 2'b01;
  localparam logic [1:0] SEND_ACK  = 2'b10;

  function automatic logic is_onehot(input logic [31:0] v);
    return (v != 32'd0) && ((v & (v - 32'd1)) == 32'd0);
  endfunction

  function automatic logic send_legal(input logic [1:0] v);
    return v != 2'b11;
  endfunction
endpackage

// File: rtl/mbx_ctrl.sv
module mbx_ctrl
  import mbx_pkg::*;
#(
  parameter int NUM_CORES = 32,
  parameter int ADDR_W    = 4,
  parameter int BUS_W     = 32,
  localparam int CID_W    = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic [BUS_W-1:0]     wr_data,
  input  logic [CID_W-1:0]     wr_core,
  output logic [NUM_CORES-1:0] owner,
  output logic [NUM_CORES-1:0] dst,
  output logic [1:0]           mode,
  output logic [1:0]           send,
  output logic                 owned
);
  logic [NUM_CORES-1:0] wr_bit, wr_mask;
  logic hit_owner, hit_dset, hit_dclr, hit_mode, hit_send;
  logic claim_ok, release_ok, send_wr_ok, send_drop, auto_fire, outsider;

  assign wr_bit    = NUM_CORES'(1) << wr_core;
  assign wr_mask   = wr_data[NUM_CORES-1:0];
  assign owned     = |owner;
  assign hit_owner = wr_en && (wr_addr == ADDR_W'(A_OWNER));
  assign hit_dset  = wr_en && owned && (wr_addr == ADDR_W'(A_DSET));
  assign hit_dclr  = wr_en && owned && (wr_addr == ADDR_W'(A_DCLR));
  assign hit_mode  = wr_en && owned && (wr_addr == ADDR_W'(A_MODE));
  assign hit_send  = wr_en && owned && (wr_addr == ADDR_W'(A_SEND));

  assign claim_ok   = hit_owner && !owned && is_onehot(32'(wr_data))
                      && ((64'(wr_data) >> NUM_CORES) == 64'd0);
  assign release_ok = hit_owner && owned && ((owner & wr_bit) != '0)
                      && (wr_data == '0);
  assign outsider   = ((owner | dst) & wr_bit) == '0;
  assign send_wr_ok = hit_send && !outsider && send_legal(wr_data[1:0]);
  assign send_drop  = hit_send && !send_wr_ok;
  assign auto_fire  = mode[0] && (send == SEND_MSG) && (dst == '0);

  always_ff @(posedge clk) begin
    if (!rst_n || release_ok) begin
      owner <= '0;
      dst   <= '0;
      mode  <= 2'b00;
      send  <= SEND_IDLE;
    end else begin
      if (claim_ok)      owner <= wr_mask;
      if (hit_dset)      dst   <= dst | wr_mask;
      else if (hit_dclr) dst   <= dst & ~wr_mask;
      if (hit_mode)      mode  <= wr_data[1:0];
      if (auto_fire)       send <= SEND_ACK;
      else if (send_wr_ok) send <= wr_data[1:0];
    end
  end

  a_r3_never_both: assert property (@(posedge clk) disable iff (!rst_n)
    send != 2'b11);
  a_r3_drop_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (send_drop && !auto_fire) |=> $stable(send));
  a_r4_unowned_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !owned |-> (send == SEND_IDLE && mode == 2'b00 && dst == '0));
  a_r5_release_clears: assert property (@(posedge clk) disable iff (!rst_n)
    release_ok |=> (owner == '0 && send == SEND_IDLE && dst == '0));
  a_r5_owner_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(owner));
  a_r7_auto_ack: assert property (@(posedge clk) disable iff (!rst_n)
    auto_fire |=> send == SEND_ACK);
  a_r9_manual_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode[0] && send == SEND_MSG && !hit_send && !release_ok) |=> send == SEND_MSG);
endmodule

// File: rtl/mbx_data.sv
module mbx_data
  import mbx_pkg::*;
#(
  parameter int NUM_DATA = 4,
  parameter int ADDR_W   = 4,
  parameter int BUS_W    = 32
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en,
  input  logic                           owned,
  input  logic [ADDR_W-1:0]              wr_addr,
  input  logic [BUS_W-1:0]               wr_data,
  output logic [NUM_DATA-1:0][BUS_W-1:0] words
);
  for (genvar i = 0; i < NUM_DATA; i++) begin : g_word
    logic we;
    assign we = wr_en && owned && (wr_addr == ADDR_W'(A_DATA0 + i));
    always_ff @(posedge clk) begin
      if (!rst_n)  words[i] <= '0;
      else if (we) words[i] <= wr_data;
    end
  end

  a_r4_data_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !owned) |=> $stable(words));
endmodule

// File: rtl/mbx_irq.sv
module mbx_irq
  import mbx_pkg::*;
#(
  parameter int NUM_CORES = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_CORES-1:0] owner,
  input  logic [NUM_CORES-1:0] dst,
  input  logic [1:0]           send,
  output logic [NUM_CORES-1:0] irq
);
  for (genvar i = 0; i < NUM_CORES; i++) begin : g_line
    assign irq[i] = (send[0] && dst[i]) || (send[1] && owner[i]);
  end

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (send == SEND_IDLE) |-> irq == '0);
  a_r2_ack_to_owner: assert property (@(posedge clk) disable iff (!rst_n)
    (send == SEND_ACK) |-> ($countones(irq) <= 1 && (irq & ~owner) == '0));
  a_r1_msg_to_dst: assert property (@(posedge clk) disable iff (!rst_n)
    (send == SEND_MSG) |-> (irq & ~dst) == '0);
endmodule

// File: rtl/ipc_mailbox.sv
module ipc_mailbox
  import mbx_pkg::*;
#(
  parameter int NUM_CORES = 32,
  parameter int NUM_DATA  = 4,
  parameter int ADDR_W    = 4,
  parameter int BUS_W     = 32,
  localparam int CID_W    = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic [BUS_W-1:0]     wr_data,
  input  logic [CID_W-1:0]     wr_core,
  input  logic [ADDR_W-1:0]    rd_addr,
  output logic [BUS_W-1:0]     rd_data,
  output logic [NUM_CORES-1:0] irq
);
  logic [NUM_CORES-1:0] owner, dst;
  logic [1:0] mode, send;
  logic owned;
  logic [NUM_DATA-1:0][BUS_W-1:0] words;

  mbx_ctrl #(.NUM_CORES(NUM_CORES), .ADDR_W(ADDR_W), .BUS_W(BUS_W)) u_ctrl (
    .clk, .rst_n, .wr_en, .wr_addr, .wr_data, .wr_core,
    .owner, .dst, .mode, .send, .owned
  );

  mbx_data #(.NUM_DATA(NUM_DATA), .ADDR_W(ADDR_W), .BUS_W(BUS_W)) u_data (
    .clk, .rst_n, .wr_en, .owned, .wr_addr, .wr_data, .words
  );

  mbx_irq #(.NUM_CORES(NUM_CORES)) u_irq (
    .clk, .rst_n, .owner, .dst, .send, .irq
  );

  always_comb begin
    rd_data = '0;
    if (rd_addr == ADDR_W'(A_OWNER))      rd_data = BUS_W'(owner);
    else if (rd_addr == ADDR_W'(A_DSET) ||
             rd_addr == ADDR_W'(A_DCLR))  rd_data = BUS_W'(dst);
    else if (rd_addr == ADDR_W'(A_MODE))  rd_data = BUS_W'(mode);
    else if (rd_addr == ADDR_W'(A_SEND))  rd_data = BUS_W'(send);
    for (int i = 0; i < NUM_DATA; i++)
      if (rd_addr == ADDR_W'(A_DATA0 + i)) rd_data = words[i];
  end
endmodule

// File: tb/ipc_mailbox_tb.sv
module ipc_mailbox_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [4:0]  wr_core = '0;
  logic [3:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic [31:0] irq;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  ipc_mailbox u_dut (.clk, .rst_n, .wr_en, .wr_addr, .wr_data, .wr_core,
                     .rd_addr, .rd_data, .irq);

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input int core, input int addr, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_core = 5'(core); wr_addr = 4'(addr); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int addr, output logic [31:0] d);
    rd_addr = 4'(addr);
    #1 d = rd_data;
  endtask

  task automatic chk_reg(input string req, input int addr, input logic [31:0] exp);
    logic [31:0] v;
    rd(addr, v);
    check(req, v, exp);
  endtask

  task automatic t_reset();
    check("R5 reset irq", irq, 32'h0);
    chk_reg("R5 reset owner", 0, 32'h0);
    chk_reg("R3 reset send", 4, 32'h0);
  endtask

  task automatic t_unclaimed();   // R4
    wr(2, 4, 32'h1);
    chk_reg("R4 send locked", 4, 32'h0);
    check("R4 irq quiet", irq, 32'h0);
    wr(2, 8, 32'h1234_5678);
    chk_reg("R4 data locked", 8, 32'h0);
    wr(2, 3, 32'h3);
    chk_reg("R4 mode locked", 3, 32'h0);
    wr(2, 1, 32'h20);
    chk_reg("R4 dst locked", 1, 32'h0);
  endtask

  task automatic t_claim();   // R5
    wr(2, 0, 32'h6);
    chk_reg("R5 non-onehot claim", 0, 32'h0);
    wr(2, 0, 32'h4);
    chk_reg("R5 claim", 0, 32'h4);
    wr(3, 0, 32'h8);
    chk_reg("R5 second claim", 0, 32'h4);
  endtask

  task automatic t_manual();
    wr(2, 8, 32'hCAFE_F00D);
    wr(2, 11, 32'h0BAD_BEEF);
    chk_reg("R10 data0", 8, 32'hCAFE_F00D);
    chk_reg("R10 data3", 11, 32'h0BAD_BEEF);
    wr(2, 1, 32'h220);
    wr(2, 4, 32'h1);
    check("R1 msg irq", irq, 32'h220);
    wr(7, 4, 32'h0);
    chk_reg("R6 outsider send", 4, 32'h1);
    check("R6 outsider irq", irq, 32'h220);
    wr(5, 2, 32'h20);
    check("R1 dst drop", irq, 32'h200);
    wr(9, 2, 32'h200);
    @(negedge clk);
    chk_reg("R9 no auto ack", 4, 32'h1);
    check("R9 irq none", irq, 32'h0);
    wr(2, 1, 32'h200);
    check("R1 irq back", irq, 32'h200);
    wr(9, 4, 32'h0);
    check("R1 clear irq", irq, 32'h0);
    wr(2, 4, 32'h1);
    wr(9, 4, 32'h2);
    chk_reg("R3 01 to 10", 4, 32'h2);
    check("R2 ack irq", irq, 32'h4);
    wr(9, 4, 32'h3);
    chk_reg("R3 11 dropped", 4, 32'h2);
    wr(2, 4, 32'h0);
    check("R2 ack cleared", irq, 32'h0);
  endtask

  task automatic t_release();   // R5, R10
    wr(2, 3, 32'h3);
    chk_reg("R10 mode link", 3, 32'h3);
    wr(2, 4, 32'h1);
    wr(5, 0, 32'h0);
    chk_reg("R5 foreign release", 0, 32'h4);
    wr(2, 0, 32'h0);
    chk_reg("R5 owner clear", 0, 32'h0);
    chk_reg("R5 mode clear", 3, 32'h0);
    chk_reg("R5 dst clear", 1, 32'h0);
    chk_reg("R5 send clear", 4, 32'h0);
    check("R5 irq drop", irq, 32'h0);
  endtask

  task automatic t_auto_multi();   // R7
    wr(0, 0, 32'h1);
    wr(0, 3, 32'h1);
    wr(0, 1, 32'h8000_0088);
    wr(0, 4, 32'h1);
    check("R7 msg irq", irq, 32'h8000_0088);
    wr(3, 2, 32'h8);
    chk_reg("R7 partial", 4, 32'h1);
    wr(7, 2, 32'h80);
    wr(31, 2, 32'h8000_0000);
    chk_reg("R7 no early ack", 4, 32'h1);
    @(negedge clk);
    chk_reg("R7 auto ack", 4, 32'h2);
    check("R7 owner irq", irq, 32'h1);
    wr(0, 0, 32'h0);
  endtask

  task automatic t_auto_single();   // R8
    wr(1, 0, 32'h2);
    wr(1, 3, 32'h1);
    wr(1, 1, 32'h10);
    wr(1, 4, 32'h1);
    check("R8 msg irq", irq, 32'h10);
    wr(4, 2, 32'h10);
    @(negedge clk);
    check("R8 ack irq", irq, 32'h2);
    wr(1, 0, 32'h0);
    check("R8 released", irq, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_unclaimed();
    t_claim();
    t_manual();
    t_release();
    t_auto_multi();
    t_auto_single();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule